// File: doc/BRIEF.md
# Perceptron Branch Direction Predictor

This block predicts whether a conditional branch is taken. It keeps a global history register of recent branch outcomes and a table of perceptrons. The low bits of the branch PC select one perceptron. Each perceptron holds a signed bias and one signed weight per history bit. The prediction is the sign of the bias plus the dot product of the weights with the history. In that dot product a taken history bit counts as +1 and a not-taken bit counts as -1.

A single request port carries two kinds of operation. A lookup only returns the predicted direction. A training operation also carries the resolved outcome. It returns the prediction the block would have made, trains the selected perceptron when that is needed, shifts the outcome into the history and counts the result as right or wrong. The dot product is summed over several cycles, a few terms per cycle. While an operation is in flight the port accepts nothing new, and a one-cycle done strobe marks the end.

Top module: `percep_predictor`

## Requirements
- R1: After reset, `req_ready` is 1, `rsp_done` is 0, `global_hist` is all zeros, and both counters are zero.
- R2: A request is accepted on a clock edge where `req_valid` and `req_ready` are both 1. `req_ready` is 0 from the next cycle until the done cycle has ended. A request presented while `req_ready` is 0 has no effect.
- R3: `rsp_done` is high for exactly one cycle. Counting the acceptance edge as edge 0, it rises after edge NCHUNK, where NCHUNK = ceil((HIST_LEN+1)/LANES). `rsp_taken` is valid in that cycle.
- R4: The activation is the bias plus the sum over i of x_i*w_i, where x_i = +1 if `global_hist[i]` is 1 (taken) and -1 otherwise. `rsp_taken` is 1 (taken) exactly when the activation is >= 0. An entry never trained has all-zero weights and so predicts taken.
- R5: The entry is selected by `req_pc` modulo ENTRIES (its low log2(ENTRIES) bits), so PCs that differ by a multiple of ENTRIES share one perceptron.
- R6: A training operation adjusts the weights when the prediction was wrong, or when |activation| <= floor((193*HIST_LEN+1400)/100). In that case, with t = +1 for a taken outcome and -1 otherwise, the bias moves by t and each w_i moves by t*x_i. Otherwise the weights are left unchanged.
- R7: Weights are WEIGHT_W-bit two's-complement values that saturate at -2^(WEIGHT_W-1) and 2^(WEIGHT_W-1)-1.
- R8: When a training operation completes, `global_hist` shifts one place toward the MSB, and the outcome enters bit 0 (1 = taken). At no other time does `global_hist` change.
- R9: When a training operation completes, `hit_count` increases by one if the prediction equalled the outcome, and `miss_count` increases by one otherwise. At no other time do the counters change.
- R10: A lookup (`req_train` = 0) changes no weight, no history bit and no counter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_train | input | 1 | 1 = training operation, 0 = lookup |
| req_pc | input | PC_W | Branch PC |
| req_taken | input | 1 | Resolved outcome for training (1 = taken) |
| req_ready | output | 1 | Block idle and able to accept a request |
| rsp_done | output | 1 | One-cycle strobe at the end of an operation |
| rsp_taken | output | 1 | Predicted direction, valid with `rsp_done` |
| global_hist | output | HIST_LEN | Global outcome history, bit 0 newest |
| hit_count | output | CNT_W | Number of trained branches predicted correctly |
| miss_count | output | CNT_W | Number of trained branches predicted wrongly |

## Verification
The assertions check the handshake on every cycle:
- readiness drops after acceptance;
- the done strobe lasts one cycle and is followed by readiness;
- history and counters move only right after a done strobe;
- history moves only as a one-place shift;
- at most one counter steps per operation.

The arithmetic is shown only by the bench's scenarios, which compare against a model of the table. Those scenarios cover:
- the sign rule;
- the modulo indexing;
- the training threshold, which decides how many opposite outcomes are needed to flip a learned prediction;
- weight saturation under a long pseudo-random stream;
- that lookups and requests made while busy leave the state untouched.

// File: rtl/percep_pkg.sv
package percep_pkg;

    typedef enum logic [1:0] {
        PS_IDLE = 2'd0,
        PS_SUM  = 2'd1,
        PS_FIN  = 2'd2
    } pstate_e;

    typedef struct packed {
        logic train;
        logic outcome;
    } op_t;

    function automatic int ceil_div(input int a, input int b);
        return (a + b - 1) / b;
    endfunction

    // Training margin floor(1.93*h + 14) in integer arithmetic
    function automatic int train_floor(input int h);
        return (193 * h + 1400) / 100;
    endfunction

endpackage

// File: rtl/percep_table.sv
module percep_table #(
    parameter int ENTRIES = 1024,
    parameter int ROW_W   = 104,
    parameter int IDX_W   = 10
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             rd_en,
    input  logic [IDX_W-1:0] rd_idx,
    output logic [ROW_W-1:0] rd_row,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [ROW_W-1:0] wr_row
);
    logic [ROW_W-1:0]   mem [ENTRIES];
    logic [ENTRIES-1:0] written_q;

    // Entries never written read as all-zero weights
    always_ff @(posedge clk) begin
        if (rst) begin
            written_q <= '0;
        end else if (wr_en) begin
            written_q[wr_idx] <= 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (wr_en) begin
            mem[wr_idx] <= wr_row;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_row <= '0;
        end else if (rd_en) begin
            rd_row <= written_q[rd_idx] ? mem[rd_idx] : '0;
        end
    end
endmodule

// File: rtl/percep_accum.sv
module percep_accum #(
    parameter int HIST_LEN = 12,
    parameter int WEIGHT_W = 8,
    parameter int LANES    = 4,
    parameter int ACC_W    = 13,
    parameter int CHUNK_W  = 2
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         clear,
    input  logic                         en,
    input  logic [CHUNK_W-1:0]           chunk,
    input  logic [(HIST_LEN+1)*WEIGHT_W-1:0] row,
    input  logic [HIST_LEN-1:0]          hist,
    output logic signed [ACC_W-1:0]      acc
);
    localparam int NT     = HIST_LEN + 1;
    localparam int NSLOTS = percep_pkg::ceil_div(NT, LANES) * LANES;
    localparam int TI_W   = (NSLOTS > 1) ? $clog2(NSLOTS) : 1;
    localparam int TSZ    = 1 << TI_W;

    logic signed [ACC_W-1:0] term [TSZ];
    logic signed [ACC_W-1:0] chunk_sum;

    // Signed contribution of each term; padding slots are zero
    for (genvar k = 0; k < TSZ; k++) begin : g_term
        if (k == 0) begin : g_bias
            assign term[k] = ACC_W'($signed(row[WEIGHT_W-1:0]));
        end else if (k < NT) begin : g_wt
            logic signed [ACC_W-1:0] ext;
            assign ext     = ACC_W'($signed(row[k*WEIGHT_W +: WEIGHT_W]));
            assign term[k] = hist[k-1] ? ext : -ext;
        end else begin : g_pad
            assign term[k] = '0;
        end
    end

    always_comb begin
        chunk_sum = '0;
        for (int l = 0; l < LANES; l++) begin
            chunk_sum = chunk_sum + term[TI_W'(int'(chunk) * LANES + l)];
        end
    end

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            acc <= '0;
        end else if (en) begin
            acc <= acc + chunk_sum;
        end
    end
endmodule

// File: rtl/percep_trainer.sv
module percep_trainer #(
    parameter int HIST_LEN = 12,
    parameter int WEIGHT_W = 8,
    parameter int ACC_W    = 13,
    parameter int THETA    = 37
) (
    input  logic [(HIST_LEN+1)*WEIGHT_W-1:0] row_in,
    input  logic [HIST_LEN-1:0]              hist,
    input  logic                             outcome,
    input  logic signed [ACC_W-1:0]          act,
    output logic                             pred,
    output logic                             do_train,
    output logic [(HIST_LEN+1)*WEIGHT_W-1:0] row_out
);
    localparam int NT = HIST_LEN + 1;
    localparam logic signed [WEIGHT_W-1:0] W_MAX = {1'b0, {(WEIGHT_W-1){1'b1}}};
    localparam logic signed [WEIGHT_W-1:0] W_MIN = {1'b1, {(WEIGHT_W-1){1'b0}}};
    localparam logic signed [ACC_W-1:0]    MARGIN = ACC_W'(THETA);

    logic signed [ACC_W-1:0] mag;

    assign pred     = ~act[ACC_W-1];
    assign mag      = act[ACC_W-1] ? -act : act;
    assign do_train = (pred != outcome) || (mag <= MARGIN);

    for (genvar g = 0; g < NT; g++) begin : g_wt
        logic                       up;
        logic signed [WEIGHT_W-1:0] cur;
        logic signed [WEIGHT_W-1:0] nxt;
        if (g == 0) begin : g_bias
            assign up = outcome;
        end else begin : g_corr
            assign up = (outcome == hist[g-1]);
        end
        assign cur = row_in[g*WEIGHT_W +: WEIGHT_W];
        always_comb begin
            if (up) begin
                nxt = (cur == W_MAX) ? cur : cur + WEIGHT_W'(1);
            end else begin
                nxt = (cur == W_MIN) ? cur : cur - WEIGHT_W'(1);
            end
        end
        assign row_out[g*WEIGHT_W +: WEIGHT_W] = do_train ? nxt : cur;
    end
endmodule

// File: rtl/percep_predictor.sv
module percep_predictor
    import percep_pkg::*;
#(
    parameter int PC_W     = 32,
    parameter int HIST_LEN = 12,
    parameter int ENTRIES  = 1024,
    parameter int WEIGHT_W = 8,
    parameter int LANES    = 4,
    parameter int CNT_W    = 32
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                req_valid,
    input  logic                req_train,
    input  logic [PC_W-1:0]     req_pc,
    input  logic                req_taken,
    output logic                req_ready,
    output logic                rsp_done,
    output logic                rsp_taken,
    output logic [HIST_LEN-1:0] global_hist,
    output logic [CNT_W-1:0]    hit_count,
    output logic [CNT_W-1:0]    miss_count
);
    localparam int NT      = HIST_LEN + 1;
    localparam int NCHUNK  = ceil_div(NT, LANES);
    localparam int CHUNK_W = (NCHUNK > 1) ? $clog2(NCHUNK) : 1;
    localparam int ROW_W   = NT * WEIGHT_W;
    localparam int IDX_W   = $clog2(ENTRIES);
    localparam int ACC_W   = $clog2(NT * (1 << (WEIGHT_W - 1))) + 2;
    localparam int THETA   = train_floor(HIST_LEN);

    pstate_e                 state_q;
    logic [CHUNK_W-1:0]      chunk_q;
    op_t                     op_q;
    logic [IDX_W-1:0]        idx_q;
    logic [HIST_LEN-1:0]     hist_q;
    logic [CNT_W-1:0]        hit_q;
    logic [CNT_W-1:0]        miss_q;
    logic [ROW_W-1:0]        row_rd;
    logic [ROW_W-1:0]        row_wr;
    logic signed [ACC_W-1:0] act;
    logic                    accept;
    logic                    fin;
    logic                    pred;
    logic                    do_train;

    assign accept = req_valid && (state_q == PS_IDLE);
    assign fin    = (state_q == PS_FIN);

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= PS_IDLE;
            chunk_q <= '0;
            op_q    <= '0;
            idx_q   <= '0;
            hist_q  <= '0;
            hit_q   <= '0;
            miss_q  <= '0;
        end else begin
            case (state_q)
                PS_IDLE: begin
                    if (accept) begin
                        state_q      <= PS_SUM;
                        chunk_q      <= '0;
                        op_q.train   <= req_train;
                        op_q.outcome <= req_taken;
                        idx_q        <= req_pc[IDX_W-1:0];
                    end
                end
                PS_SUM: begin
                    if (chunk_q == CHUNK_W'(NCHUNK - 1)) begin
                        state_q <= PS_FIN;
                    end else begin
                        chunk_q <= chunk_q + CHUNK_W'(1);
                    end
                end
                PS_FIN: begin
                    state_q <= PS_IDLE;
                    if (op_q.train) begin
                        hist_q <= {hist_q[HIST_LEN-2:0], op_q.outcome};
                        if (pred == op_q.outcome) begin
                            hit_q <= hit_q + CNT_W'(1);
                        end else begin
                            miss_q <= miss_q + CNT_W'(1);
                        end
                    end
                end
                default: state_q <= PS_IDLE;
            endcase
        end
    end

    percep_table #(
        .ENTRIES (ENTRIES),
        .ROW_W   (ROW_W),
        .IDX_W   (IDX_W)
    ) table_i (
        .clk    (clk),
        .rst    (rst),
        .rd_en  (accept),
        .rd_idx (req_pc[IDX_W-1:0]),
        .rd_row (row_rd),
        .wr_en  (fin && op_q.train && do_train),
        .wr_idx (idx_q),
        .wr_row (row_wr)
    );

    percep_accum #(
        .HIST_LEN (HIST_LEN),
        .WEIGHT_W (WEIGHT_W),
        .LANES    (LANES),
        .ACC_W    (ACC_W),
        .CHUNK_W  (CHUNK_W)
    ) accum_i (
        .clk   (clk),
        .rst   (rst),
        .clear (accept),
        .en    (state_q == PS_SUM),
        .chunk (chunk_q),
        .row   (row_rd),
        .hist  (hist_q),
        .acc   (act)
    );

    percep_trainer #(
        .HIST_LEN (HIST_LEN),
        .WEIGHT_W (WEIGHT_W),
        .ACC_W    (ACC_W),
        .THETA    (THETA)
    ) trainer_i (
        .row_in   (row_rd),
        .hist     (hist_q),
        .outcome  (op_q.outcome),
        .act      (act),
        .pred     (pred),
        .do_train (do_train),
        .row_out  (row_wr)
    );

    assign req_ready   = (state_q == PS_IDLE);
    assign rsp_done    = fin;
    assign rsp_taken   = pred;
    assign global_hist = hist_q;
    assign hit_count   = hit_q;
    assign miss_count  = miss_q;
endmodule

// File: rtl/percep_predictor_chk.sv
module percep_predictor_chk #(
    parameter int HIST_LEN = 12,
    parameter int CNT_W    = 32
) (
    input logic                clk,
    input logic                rst,
    input logic                req_valid,
    input logic                req_ready,
    input logic                rsp_done,
    input logic [HIST_LEN-1:0] global_hist,
    input logic [CNT_W-1:0]    hit_count,
    input logic [CNT_W-1:0]    miss_count
);
    AST_DONE_NOT_READY: assert property (@(posedge clk) disable iff (rst)
        rsp_done |-> !req_ready) else $error("done while ready"); // R2

    AST_ACCEPT_GOES_BUSY: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready) |=> (!req_ready && !rsp_done)) else $error("accept not busy"); // R2

    AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
        rsp_done |=> (!rsp_done && req_ready)) else $error("done strobe too long"); // R3

    AST_HIST_HOLD: assert property (@(posedge clk) disable iff (rst)
        !$past(rsp_done) |-> $stable(global_hist)) else $error("history moved"); // R8

    AST_HIST_SHIFT: assert property (@(posedge clk) disable iff (rst)
        ($past(rsp_done) && (global_hist != $past(global_hist)))
        |-> (global_hist[HIST_LEN-1:1] == $past(global_hist[HIST_LEN-2:0])))
        else $error("history not a shift"); // R8

    AST_COUNT_HOLD: assert property (@(posedge clk) disable iff (rst)
        !$past(rsp_done) |-> ($stable(hit_count) && $stable(miss_count)))
        else $error("counter moved"); // R9

    AST_COUNT_ONE: assert property (@(posedge clk) disable iff (rst)
        $past(rsp_done) |-> ($stable(hit_count) || $stable(miss_count)))
        else $error("both counters moved"); // R9
endmodule

bind percep_predictor percep_predictor_chk #(
    .HIST_LEN (HIST_LEN),
    .CNT_W    (CNT_W)
) chk_i (
    .clk         (clk),
    .rst         (rst),
    .req_valid   (req_valid),
    .req_ready   (req_ready),
    .rsp_done    (rsp_done),
    .global_hist (global_hist),
    .hit_count   (hit_count),
    .miss_count  (miss_count)
);

// File: tb/percep_predictor_tb_top.sv
module percep_predictor_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int PC_W     = 16;
    localparam int HL       = 6;
    localparam int ENTRIES  = 64;
    localparam int WW       = 4;
    localparam int LANES    = 3;
    localparam int CNT_W    = 16;
    localparam int NT       = HL + 1;
    localparam int NCHUNK   = (NT + LANES - 1) / LANES;
    localparam int LAT      = NCHUNK + 1;
    localparam int THETA    = (193 * HL + 1400) / 100;
    localparam int WMAX     = (1 << (WW - 1)) - 1;
    localparam int WMIN     = -(1 << (WW - 1));

    logic clk = 1'b0;
    logic rst;
    logic req_valid, req_train, req_taken;
    logic [PC_W-1:0] req_pc;
    logic req_ready, rsp_done, rsp_taken;
    logic [HL-1:0] global_hist;
    logic [CNT_W-1:0] hit_count, miss_count;

    percep_predictor #(
        .PC_W(PC_W), .HIST_LEN(HL), .ENTRIES(ENTRIES),
        .WEIGHT_W(WW), .LANES(LANES), .CNT_W(CNT_W)
    ) dut_i (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_train(req_train),
        .req_pc(req_pc), .req_taken(req_taken), .req_ready(req_ready),
        .rsp_done(rsp_done), .rsp_taken(rsp_taken), .global_hist(global_hist),
        .hit_count(hit_count), .miss_count(miss_count)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    int n_checks = 0;
    int n_errors = 0;
    int mw [ENTRIES][NT];
    logic [HL-1:0] m_hist;
    int m_hit, m_miss;
    logic [15:0] lfsr = 16'hACE1;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic int m_act(input int idx);
        int s = mw[idx][0];
        for (int i = 0; i < HL; i++) s += m_hist[i] ? mw[idx][i+1] : -mw[idx][i+1];
        return s;
    endfunction

    task automatic m_train(input int idx, input logic taken, input int a);
        logic p = (a >= 0);
        int mag = (a < 0) ? -a : a;
        if ((p != taken) || (mag <= THETA)) begin
            for (int j = 0; j < NT; j++) begin
                logic up = (j == 0) ? taken : (taken == m_hist[j-1]);
                if (up && mw[idx][j] < WMAX) mw[idx][j]++;
                if (!up && mw[idx][j] > WMIN) mw[idx][j]--;
            end
        end
        m_hist = {m_hist[HL-2:0], taken};
        if (p == taken) m_hit++; else m_miss++;
    endtask

    // One operation; checks latency, prediction and resulting state
    task automatic run_op(input logic [PC_W-1:0] pc, input logic train,
                          input logic taken, input string tag);
        int idx = int'(pc) % ENTRIES;
        int a = m_act(idx);
        logic p = (a >= 0);
        int lat = 1;
        @(negedge clk);
        chk(req_ready == 1'b1, "R2 ready before request", int'(req_ready), 1);
        req_valid = 1'b1; req_train = train; req_pc = pc; req_taken = taken;
        @(negedge clk);
        req_valid = 1'b0;
        while (!rsp_done && lat < 40) begin
            @(negedge clk);
            lat++;
        end
        chk(lat == LAT, "R3 done latency", lat, LAT);
        chk(rsp_taken == p, tag, int'(rsp_taken), int'(p));
        if (train) m_train(idx, taken, a);
        @(negedge clk);
        chk(rsp_done == 1'b0, "R3 done one cycle", int'(rsp_done), 0);
        chk(global_hist == m_hist, train ? "R8 history" : "R10 history", int'(global_hist), int'(m_hist));
        chk(int'(hit_count) == m_hit, train ? "R9 hit count" : "R10 hit count", int'(hit_count), m_hit);
        chk(int'(miss_count) == m_miss, train ? "R9 miss count" : "R10 miss count", int'(miss_count), m_miss);
    endtask

    task automatic t_reset;
        @(negedge clk);
        chk(req_ready == 1'b1, "R1 ready", int'(req_ready), 1);
        chk(rsp_done == 1'b0, "R1 done", int'(rsp_done), 0);
        chk(global_hist == '0, "R1 history", int'(global_hist), 0);
        chk(hit_count == '0 && miss_count == '0, "R1 counters", int'(hit_count) + int'(miss_count), 0);
    endtask

    task automatic t_fresh;
        run_op(16'h0011, 1'b0, 1'b0, "R4 untrained entry predicts taken");
        chk(rsp_taken == 1'b1, "R4 zero activation is taken", int'(rsp_taken), 1);
    endtask

    task automatic t_learn;
        for (int n = 0; n < 10; n++) run_op(16'h0005, 1'b1, 1'b0, "R6 learn not taken");
        run_op(16'h0005, 1'b0, 1'b0, "R10 lookup after learning");
    endtask

    task automatic t_alias;
        chk(m_act(5) < 0, "R5 bench precondition entry not taken", m_act(5), -1);
        run_op(16'h0005 + ENTRIES, 1'b0, 1'b0, "R5 alias plus one table");
        run_op(16'h0005 + 3 * ENTRIES, 1'b0, 1'b0, "R5 alias plus three tables");
        run_op(16'h0006, 1'b0, 1'b0, "R5 neighbour entry untouched");
    endtask

    task automatic t_threshold;
        for (int n = 0; n < 20; n++) run_op(16'h0014, 1'b1, 1'b1, "R6 confident taken");
        for (int n = 0; n < 15; n++) run_op(16'h0014, 1'b1, 1'b0, "R6 flip after threshold");
    endtask

    task automatic t_busy;
        int a = m_act(33);
        logic p = (a >= 0);
        @(negedge clk);
        req_valid = 1'b1; req_train = 1'b1; req_pc = 16'd33; req_taken = 1'b1;
        @(negedge clk);
        req_pc = 16'd40; req_taken = 1'b0;
        while (!rsp_done) begin
            chk(req_ready == 1'b0, "R2 busy not ready", int'(req_ready), 0);
            @(negedge clk);
        end
        chk(rsp_taken == p, "R2 first request served", int'(rsp_taken), int'(p));
        req_valid = 1'b0;
        m_train(33, 1'b1, a);
        @(negedge clk);
        chk(global_hist == m_hist, "R2 held request ignored history", int'(global_hist), int'(m_hist));
        chk(int'(hit_count) + int'(miss_count) == m_hit + m_miss, "R2 held request ignored count",
            int'(hit_count) + int'(miss_count), m_hit + m_miss);
        @(negedge clk);
        chk(rsp_done == 1'b0 && req_ready == 1'b1, "R2 no second operation", int'(rsp_done), 0);
        run_op(16'd40, 1'b0, 1'b0, "R2 entry of ignored request untouched");
    endtask

    task automatic t_saturate;
        for (int n = 0; n < 300; n++) begin
            logic [PC_W-1:0] pc;
            run_op(16'd9, 1'b1, 1'b1, "R7 saturating bias stream");
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            pc = {8'h00, lfsr[7:0]};
            if ((int'(pc) % ENTRIES) == 9) pc = pc + 16'd1;
            run_op(pc, 1'b1, lfsr[9], "R7 random neighbour");
        end
        chk(mw[9][0] == WMAX, "R7 bench model reached limit", mw[9][0], WMAX);
        for (int n = 0; n < 6; n++) run_op(16'd9, 1'b1, 1'b0, "R7 unwind from limit");
    endtask

    initial begin
        for (int e = 0; e < ENTRIES; e++) for (int j = 0; j < NT; j++) mw[e][j] = 0;
        m_hist = '0; m_hit = 0; m_miss = 0;
        rst = 1'b1; req_valid = 1'b0; req_train = 1'b0; req_pc = '0; req_taken = 1'b0;
        repeat (5) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_fresh();
        t_learn();
        t_alias();
        t_threshold();
        t_busy();
        t_saturate();
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 150000);
        n_checks++;
        n_errors++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end
endmodule